// File: doc/BRIEF.md
# Multiplexed DRAM Address Sequencer

This block sits between a host that issues single-word read and write requests and a dynamic memory array of 256 rows by 256 columns. The host presents a 16-bit word address, a direction bit and, for writes, a data byte. The sequencer then drives the two halves of that address over one 8-bit bus, one half after the other, framed by two active-low strobes. The upper half goes out first and is taken by the row strobe. The lower half follows and is taken by the column strobe.

Every wait between strobe edges is a parameter counted in clock cycles. These cover the address setup before the row strobe, the row settling time before the column address may replace the row address, the column address setup, the column strobe width, and the recovery time with both strobes high. While an access is in flight the block reports busy and disregards the request input. A read returns its byte together with a single-cycle valid pulse as the column phase ends.

Top module: `dram_addr_seq`

## Requirements
- R1: While reset is asserted, and on the cycle after an asynchronous reset lands in the middle of an access, `busy` and `rd_valid` are 0 and `dram_ras_n`, `dram_cas_n` and `dram_we_n` are all 1.
- R2: A request is taken when `req_valid` is 1 while `busy` is 0. `busy` is 1 from the next cycle for exactly ROW_CYC+RAS_CYC+COL_CYC+CAS_CYC+PRE_CYC cycles (11 with the defaults).
- R3: The row address `req_addr[15:8]` is on `dram_addr` for ROW_CYC cycles before `dram_ras_n` falls. `dram_cas_n` is still 1 when `dram_ras_n` falls, and it falls exactly RAS_CYC+COL_CYC cycles after `dram_ras_n` falls.
- R4: The column address `req_addr[7:0]` is on `dram_addr` when `dram_cas_n` falls. `dram_cas_n` stays low for CAS_CYC cycles and is low only while `dram_ras_n` is low. `dram_ras_n` is low for RAS_CYC+COL_CYC+CAS_CYC cycles in all.
- R5: For a write, `dram_we_n` is 0 only in cycles where `dram_cas_n` is 0, and `dram_wdata` carries the request data. A later read of the same address returns that data.
- R6: A read raises `rd_valid` for exactly one cycle, the cycle after the last column-strobe cycle, with `rd_data` equal to the byte the array drove during the column strobe. A write raises no `rd_valid`.
- R7: Both strobes are high for PRE_CYC cycles before `busy` falls. A request held high across the end of an access is taken after exactly one idle cycle.
- R8: A request presented while `busy` is 1 is ignored. It changes neither the access in flight nor the array contents.
- R9: `dram_addr` holds the same value in the cycle before each falling edge of either strobe and in the cycle of that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW (16) | Word address; upper half is the row, lower half the column |
| req_wdata | input | DW (8) | Write data |
| busy | output | 1 | Access in flight; requests are ignored |
| rd_valid | output | 1 | One-cycle pulse qualifying `rd_data` |
| rd_data | output | DW (8) | Byte returned by the last read |
| dram_addr | output | AW/2 (8) | Time-shared row/column address bus |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_wdata | output | DW (8) | Data driven to the array |
| dram_rdata | input | DW (8) | Data returned by the array |

## Verification
Two functions can land in the same cycle. One is the recovery phase that closes an access by releasing `busy`. The other is the acceptance of a new request, which the host may hold high straight across that boundary. The bench keeps `req_valid` high through a write, switches the payload to a read of the same address partway through, and checks three things: the sequencer spends exactly one cycle idle, the recovery time was not cut short, and the read returns the byte just written. A second overlap, a request raised in the middle of an access, is judged by the access length staying unchanged and the targeted address keeping its old contents.

// File: rtl/dseq_pkg.sv
package dseq_pkg;

  typedef enum logic [2:0] {
    S_IDLE      = 3'd0,
    S_ROW_SETUP = 3'd1,
    S_RAS_ON    = 3'd2,
    S_COL_SETUP = 3'd3,
    S_CAS_ON    = 3'd4,
    S_PRECHARGE = 3'd5
  } seq_state_t;

  typedef struct packed {
    logic ras_n;
    logic cas_n;
  } strobe_t;

  // Phase that follows a given phase once its wait has run out.
  function automatic seq_state_t next_phase(input seq_state_t s);
    case (s)
      S_ROW_SETUP: return S_RAS_ON;
      S_RAS_ON:    return S_COL_SETUP;
      S_COL_SETUP: return S_CAS_ON;
      S_CAS_ON:    return S_PRECHARGE;
      default:     return S_IDLE;
    endcase
  endfunction

  // Strobe levels for each phase: row strobe low from RAS_ON through CAS_ON.
  function automatic strobe_t strobe_lines(input seq_state_t s);
    strobe_t st;
    st.ras_n = !((s == S_RAS_ON) || (s == S_COL_SETUP) || (s == S_CAS_ON));
    st.cas_n = !(s == S_CAS_ON);
    return st;
  endfunction

  // Total busy cycles of one access.
  function automatic int access_cycles(input int r, input int ra, input int c,
                                       input int ca, input int p);
    return r + ra + c + ca + p;
  endfunction

endpackage

// File: rtl/dseq_timer.sv
module dseq_timer #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          expired
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (load)         cnt <= load_val;
    else if (cnt != '0)    cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/dseq_fsm.sv
module dseq_fsm
  import dseq_pkg::*;
#(
  parameter int ROW_CYC = 2,
  parameter int RAS_CYC = 3,
  parameter int COL_CYC = 2,
  parameter int CAS_CYC = 2,
  parameter int PRE_CYC = 2,
  parameter int CW      = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          expired,
  output seq_state_t    state,
  output logic          load,
  output logic [CW-1:0] load_val,
  output logic          accept,
  output logic          cas_done
);
  seq_state_t nxt;

  // Remaining-count value loaded on entry to a phase (length minus one).
  function automatic logic [CW-1:0] phase_len(input seq_state_t s);
    case (s)
      S_ROW_SETUP: return CW'(ROW_CYC - 1);
      S_RAS_ON:    return CW'(RAS_CYC - 1);
      S_COL_SETUP: return CW'(COL_CYC - 1);
      S_CAS_ON:    return CW'(CAS_CYC - 1);
      S_PRECHARGE: return CW'(PRE_CYC - 1);
      default:     return '0;
    endcase
  endfunction

  always_comb begin
    accept   = (state == S_IDLE) && req_valid;
    nxt      = state;
    if (accept)                            nxt = S_ROW_SETUP;
    else if ((state != S_IDLE) && expired) nxt = next_phase(state);
    load     = (nxt != state);
    load_val = phase_len(nxt);
    cas_done = (state == S_CAS_ON) && expired;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= S_IDLE;
    else        state <= nxt;
  end
endmodule

// File: rtl/dseq_datapath.sv
module dseq_datapath
  import dseq_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8,
  localparam int HW = AW / 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  seq_state_t    state,
  input  logic          accept,
  input  logic          cas_done,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic [DW-1:0] dram_rdata,
  output logic [HW-1:0] dram_addr,
  output logic [DW-1:0] dram_wdata,
  output logic          dram_we_n,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data
);
  logic [AW-1:0] addr_q;
  logic          wr_q;
  logic [DW-1:0] wdata_q;

  function automatic logic [HW-1:0] row_of(input logic [AW-1:0] a);
    return a[AW-1:HW];
  endfunction

  function automatic logic [HW-1:0] col_of(input logic [AW-1:0] a);
    return a[HW-1:0];
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wr_q    <= 1'b0;
      wdata_q <= '0;
    end else if (accept) begin
      addr_q  <= req_addr;
      wr_q    <= req_write;
      wdata_q <= req_wdata;
    end
  end

  always_comb begin
    case (state)
      S_ROW_SETUP, S_RAS_ON: dram_addr = row_of(addr_q);
      S_COL_SETUP, S_CAS_ON: dram_addr = col_of(addr_q);
      default:               dram_addr = '0;
    endcase
  end

  assign dram_wdata = wdata_q;
  assign dram_we_n  = !((state == S_CAS_ON) && wr_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= cas_done && !wr_q;
      if (cas_done && !wr_q) rd_data <= dram_rdata;
    end
  end
endmodule

// File: rtl/dram_addr_seq.sv
module dram_addr_seq
  import dseq_pkg::*;
#(
  parameter int AW      = 16,
  parameter int DW      = 8,
  parameter int ROW_CYC = 2,
  parameter int RAS_CYC = 3,
  parameter int COL_CYC = 2,
  parameter int CAS_CYC = 2,
  parameter int PRE_CYC = 2,
  localparam int HW     = AW / 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          busy,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data,
  output logic [HW-1:0] dram_addr,
  output logic          dram_ras_n,
  output logic          dram_cas_n,
  output logic          dram_we_n,
  output logic [DW-1:0] dram_wdata,
  input  logic [DW-1:0] dram_rdata
);
  localparam int M1   = (ROW_CYC > RAS_CYC) ? ROW_CYC : RAS_CYC;
  localparam int M2   = (COL_CYC > CAS_CYC) ? COL_CYC : CAS_CYC;
  localparam int M3   = (M1 > M2) ? M1 : M2;
  localparam int MAXC = (M3 > PRE_CYC) ? M3 : PRE_CYC;
  localparam int CW   = $clog2(MAXC) + 1;

  seq_state_t    state;
  strobe_t       strobes;
  logic          load;
  logic [CW-1:0] load_val;
  logic          expired;
  logic          ev_accept;
  logic          ev_cas_done;

  dseq_timer #(.CW(CW)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(load), .load_val(load_val), .expired(expired)
  );

  dseq_fsm #(
    .ROW_CYC(ROW_CYC), .RAS_CYC(RAS_CYC), .COL_CYC(COL_CYC),
    .CAS_CYC(CAS_CYC), .PRE_CYC(PRE_CYC), .CW(CW)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .expired(expired),
    .state(state), .load(load), .load_val(load_val),
    .accept(ev_accept), .cas_done(ev_cas_done)
  );

  dseq_datapath #(.AW(AW), .DW(DW)) u_dp (
    .clk(clk), .rst_n(rst_n), .state(state), .accept(ev_accept),
    .cas_done(ev_cas_done), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .dram_rdata(dram_rdata), .dram_addr(dram_addr),
    .dram_wdata(dram_wdata), .dram_we_n(dram_we_n), .rd_valid(rd_valid),
    .rd_data(rd_data)
  );

  assign strobes    = strobe_lines(state);
  assign dram_ras_n = strobes.ras_n;
  assign dram_cas_n = strobes.cas_n;
  assign busy       = (state != S_IDLE);
endmodule

// File: rtl/dseq_checker.sv
module dseq_checker #(
  parameter int ROW_CYC = 2,
  parameter int RAS_CYC = 3,
  parameter int COL_CYC = 2,
  parameter int PRE_CYC = 2,
  parameter int HW      = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          ev_accept,
  input logic          rd_valid,
  input logic [HW-1:0] dram_addr,
  input logic          dram_ras_n,
  input logic          dram_cas_n,
  input logic          dram_we_n
);
  logic [15:0] ras_low_cnt;
  logic [15:0] ras_high_cnt;
  logic        seen_cycle;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ras_low_cnt  <= '0;
      ras_high_cnt <= '0;
      seen_cycle   <= 1'b0;
    end else begin
      ras_low_cnt  <= dram_ras_n ? 16'd0 : ((ras_low_cnt == 16'hFFFF) ? ras_low_cnt : ras_low_cnt + 16'd1);
      ras_high_cnt <= !dram_ras_n ? 16'd0 : ((ras_high_cnt == 16'hFFFF) ? ras_high_cnt : ras_high_cnt + 16'd1);
      if (!dram_cas_n) seen_cycle <= 1'b1;
    end
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (dram_ras_n && dram_cas_n && dram_we_n)); // R1
  AST_ACCEPT_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
    ev_accept |=> busy); // R2
  AST_RAS_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dram_ras_n) |-> dram_cas_n); // R3
  AST_SETTLE_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dram_cas_n) |-> (ras_low_cnt >= 16'(RAS_CYC + COL_CYC))); // R3
  AST_CAS_UNDER_RAS: assert property (@(posedge clk) disable iff (!rst_n)
    !dram_cas_n |-> !dram_ras_n); // R4
  AST_WE_INSIDE_CAS: assert property (@(posedge clk) disable iff (!rst_n)
    !dram_we_n |-> !dram_cas_n); // R5
  AST_RDV_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid); // R6
  AST_RDV_AFTER_CAS: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> (dram_cas_n && !$past(dram_cas_n))); // R6
  AST_RECOVERY_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(dram_ras_n) && seen_cycle) |-> (ras_high_cnt >= 16'(PRE_CYC + ROW_CYC))); // R7
  AST_ACCEPT_IDLE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    ev_accept |-> !busy); // R8
  AST_ROW_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dram_ras_n) |-> $stable(dram_addr)); // R9
  AST_COL_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dram_cas_n) |-> $stable(dram_addr)); // R9
endmodule

bind dram_addr_seq dseq_checker #(
  .ROW_CYC(ROW_CYC), .RAS_CYC(RAS_CYC), .COL_CYC(COL_CYC),
  .PRE_CYC(PRE_CYC), .HW(HW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .ev_accept(ev_accept),
  .rd_valid(rd_valid), .dram_addr(dram_addr), .dram_ras_n(dram_ras_n),
  .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n)
);

// File: tb/dram_addr_seq_test.sv
`timescale 1ns/1ps

module dram_array_model #(
  parameter int NS = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] addr,
  input  logic       ras_n,
  input  logic       cas_n,
  input  logic       we_n,
  input  logic [7:0] wdata,
  output logic [7:0] rdata
);
  logic [15:0] key [NS];
  logic [7:0]  val [NS];
  logic        used [NS];
  logic        ras_p, cas_p;
  logic [7:0]  row_q;

  initial begin
    for (int i = 0; i < NS; i++) begin used[i] = 1'b0; key[i] = '0; val[i] = '0; end
    row_q = '0;
  end

  function automatic int slot_for(input logic [15:0] k);
    for (int i = 0; i < NS; i++) if (used[i] && key[i] == k) return i;
    for (int i = 0; i < NS; i++) if (!used[i]) return i;
    return 0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ras_p <= 1'b1;
      cas_p <= 1'b1;
    end else begin
      ras_p <= ras_n;
      cas_p <= cas_n;
      if (ras_p && !ras_n) row_q <= addr;
      if (cas_p && !cas_n && !we_n) begin
        key[slot_for({row_q, addr})]  <= {row_q, addr};
        val[slot_for({row_q, addr})]  <= wdata;
        used[slot_for({row_q, addr})] <= 1'b1;
      end
    end
  end

  always_comb begin
    rdata = '0;
    if (!cas_n)
      for (int i = 0; i < NS; i++)
        if (used[i] && key[i] == {row_q, addr}) rdata = val[i];
  end
endmodule

module dram_addr_seq_test;
  localparam int ROW = 2, RAS = 3, COL = 2, CAS = 2, PRE = 2;
  localparam int T_BUSY = ROW + RAS + COL + CAS + PRE;
  localparam int NVEC = 13;
  // {write, addr[15:0], data[7:0]}; for reads data is the expected byte
  localparam logic [24:0] VEC [NVEC] = '{
    {1'b1, 16'h0000, 8'h11}, {1'b1, 16'hFFFF, 8'hEE}, {1'b1, 16'h00FF, 8'h3C},
    {1'b1, 16'hFF00, 8'hC3}, {1'b1, 16'h1234, 8'hA5}, {1'b0, 16'h0000, 8'h11},
    {1'b0, 16'hFFFF, 8'hEE}, {1'b0, 16'h00FF, 8'h3C}, {1'b0, 16'hFF00, 8'hC3},
    {1'b0, 16'h1234, 8'hA5}, {1'b1, 16'h1234, 8'h5A}, {1'b0, 16'h1234, 8'h5A},
    {1'b0, 16'h4321, 8'h00}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [15:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic busy, rd_valid, dram_ras_n, dram_cas_n, dram_we_n;
  logic [7:0] rd_data, dram_addr, dram_wdata, dram_rdata;

  int tests = 0, fails = 0;

  always #2 clk = ~clk;

  dram_addr_seq #(.ROW_CYC(ROW), .RAS_CYC(RAS), .COL_CYC(COL), .CAS_CYC(CAS), .PRE_CYC(PRE)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .busy(busy), .rd_valid(rd_valid),
    .rd_data(rd_data), .dram_addr(dram_addr), .dram_ras_n(dram_ras_n),
    .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n), .dram_wdata(dram_wdata),
    .dram_rdata(dram_rdata)
  );

  dram_array_model u_mem (
    .clk(clk), .rst_n(rst_n), .addr(dram_addr), .ras_n(dram_ras_n), .cas_n(dram_cas_n),
    .we_n(dram_we_n), .wdata(dram_wdata), .rdata(dram_rdata)
  );

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Strobe monitor, sampled on falling clock edges
  logic [15:0] cur_exp = '0;
  logic pr = 1'b1, pc = 1'b1, pb = 1'b0;
  int ras_len = 0, cas_len = 0;
  always @(negedge clk) begin
    if (!rst_n) begin
      pr = 1'b1; pc = 1'b1; pb = 1'b0; ras_len = 0; cas_len = 0;
    end else begin
      if (busy && !pb) cur_exp = req_addr;
      if (pr && !dram_ras_n) begin
        check(dram_addr == cur_exp[15:8], "R3 row half at row strobe", dram_addr, cur_exp[15:8]);
        ras_len = 0;
      end
      if (!dram_ras_n) ras_len++;
      if (pc && !dram_cas_n) begin
        check(dram_addr == cur_exp[7:0], "R4 column half at column strobe", dram_addr, cur_exp[7:0]);
        check(ras_len == RAS + COL + 1, "R3 row-to-column strobe spacing", ras_len - 1, RAS + COL);
        cas_len = 0;
      end
      if (!dram_cas_n) cas_len++;
      if (!pc && dram_cas_n)
        check(cas_len == CAS, "R4 column strobe width", cas_len, CAS);
      if (!pr && dram_ras_n)
        check(ras_len == RAS + COL + CAS, "R4 row strobe width", ras_len, RAS + COL + CAS);
      pr = dram_ras_n; pc = dram_cas_n; pb = busy;
    end
  end

  // inject = 1 raises a spurious write to 16'h0000 in the middle of the access
  task automatic run_op(input bit wr, input logic [15:0] a, input logic [7:0] d, input bit inject,
                        output logic [7:0] rd, output int nvalid, output int nbusy);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    nbusy = 0; nvalid = 0; rd = '0;
    while (busy && nbusy < 100) begin
      if (inject && nbusy == 3) begin
        req_valid = 1'b1; req_write = 1'b1; req_addr = 16'h0000; req_wdata = 8'h99;
      end
      if (inject && nbusy == 7) req_valid = 1'b0;
      if (rd_valid) begin nvalid++; rd = rd_data; end
      nbusy++;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    fails++; tests++;
    $display("FAIL watchdog: actual %0d expected %0d", 50000, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [7:0] rd;
    int nv, nb, idle;
    repeat (3) @(negedge clk);
    // R1: state during reset
    check(!busy && !rd_valid, "R1 busy/rd_valid in reset", {busy, rd_valid}, 0);
    check(dram_ras_n && dram_cas_n && dram_we_n, "R1 strobes in reset",
          {dram_ras_n, dram_cas_n, dram_we_n}, 3'b111);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NVEC; i++) begin
      run_op(VEC[i][24], VEC[i][23:8], VEC[i][7:0], 1'b0, rd, nv, nb);
      check(nb == T_BUSY, "R2 busy length", nb, T_BUSY);
      if (VEC[i][24]) begin
        check(nv == 0, "R6 no valid pulse on write", nv, 0);
      end else begin
        check(nv == 1, "R6 single valid pulse on read", nv, 1);
        check(rd == VEC[i][7:0], "R5 read data matches stored", rd, VEC[i][7:0]);
      end
    end

    // R8: request during an access is ignored
    run_op(1'b0, 16'h1234, 8'h00, 1'b1, rd, nv, nb);
    check(nb == T_BUSY, "R8 access length with mid-access request", nb, T_BUSY);
    check(rd == 8'h5A, "R8 read in flight unaffected", rd, 8'h5A);
    run_op(1'b0, 16'h0000, 8'h00, 1'b0, rd, nv, nb);
    check(rd == 8'h11, "R8 ignored write left array unchanged", rd, 8'h11);
    check(nb == T_BUSY, "R2 busy length after ignored request", nb, T_BUSY);

    // R7: request held high across the end of an access
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 16'h2222; req_wdata = 8'h77;
    @(negedge clk);
    nb = 0;
    while (busy && nb < 100) begin
      if (nb == 2) begin req_write = 1'b0; req_wdata = 8'h00; end
      nb++;
      @(negedge clk);
    end
    check(nb == T_BUSY, "R7 first access length back-to-back", nb, T_BUSY);
    idle = 0;
    while (!busy && idle < 100) begin idle++; @(negedge clk); end
    check(idle == 1, "R7 one idle cycle between held requests", idle, 1);
    req_valid = 1'b0;
    nb = 0; nv = 0; rd = '0;
    while (busy && nb < 100) begin
      if (rd_valid) begin nv++; rd = rd_data; end
      nb++;
      @(negedge clk);
    end
    check(nb == T_BUSY, "R2 second access length back-to-back", nb, T_BUSY);
    check(nv == 1 && rd == 8'h77, "R5 back-to-back read returns written byte", rd, 8'h77);

    // R1: reset in the middle of an access
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = 16'h2222;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check(!busy && !rd_valid, "R1 busy/rd_valid after mid-access reset", {busy, rd_valid}, 0);
    check(dram_ras_n && dram_cas_n && dram_we_n, "R1 strobes after mid-access reset",
          {dram_ras_n, dram_cas_n, dram_we_n}, 3'b111);
    rst_n = 1'b1;
    @(negedge clk);
    run_op(1'b0, 16'h2222, 8'h00, 1'b0, rd, nv, nb);
    check(rd == 8'h77 && nv == 1, "R6 read after reset recovery", rd, 8'h77);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule